// File: doc/BRIEF.md
# Packet Commit Buffer

This block collects every architectural side effect produced while one wide instruction packet executes and holds it back until the packet ends. During the packet it takes register writes, 8-bit predicate writes, branch requests, up to two stores (one per store slot) and a cancel mask for those slots. When the packet-end pulse arrives it releases everything in a fixed order: the buffered register writes one per cycle in ascending index order, then the stores in slot order, and finally a single cycle that carries the predicate writes and the next program counter.

Predicates written several times in one packet hold the bitwise AND of all the writes. Only the first valid branch of a packet decides the next PC. With no branch, the next PC is the packet address plus the packet length. A load issued from slot 0 while slot 1 holds a live store forces that store out to memory first. The load is then granted, and the store is not sent again at commit.

Top module: `pkt_commit_buf`

## Requirements
- R1: A predicate write keeps only bits [7:0] of the request. The first write to a predicate in a packet sets its pending byte. At commit, `pred_cm_en` bit p is set for every predicate written, and its byte appears at `pred_cm_val[8p+7:8p]`.
- R2: Each further write to the same predicate in the same packet ANDs its low byte into the pending byte.
- R3: Only the first aligned branch request in a packet sets `next_pc`. Later requests in that packet are ignored.
- R4: A branch target whose bits [1:0] are not 00, arriving before any taken branch, sets `br_misalign` and does not update the next PC. A later aligned request can still take effect.
- R5: With no taken branch, `next_pc` equals the packet PC plus `pkt_len`, both captured at packet start.
- R6: A store records address, width (the byte count, 1, 2, 4 or 8) and data. When it is issued, `mem_st_data` carries only the low 8, 16, 32 or 64 bits and zeros above them.
- R7: A store request with any other width code sets `st_width_err` and is never issued.
- R8: A store whose slot bit (bit 0 = slot 0, bit 1 = slot 1) has been set in `cancel_in` during the packet is never issued.
- R9: A load held on `ld_req` with `ld_slot`=0 while slot 1 holds an uncancelled, unsent store emits that store the next cycle and asserts `ld_grant` one cycle later. Any other load is granted the cycle after the request.
- R10: After `pkt_end`, register writes leave first in ascending index order, then the slot-0 store, then the slot-1 store (a store already sent early is skipped), then one `pc_valid` cycle carrying the predicates. At most one of these outputs is active in any cycle.
- R11: Packet start clears the written flags for registers, predicates, branch and stores, together with `br_misalign` and `st_width_err`. Nothing from an earlier packet reaches a later commit.
- R12: During reset and on the cycle after it, every valid, enable and grant output is 0.
- R13: Several writes to one register in a packet commit once, with the last value written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| pkt_start | input | 1 | Start of a packet; clears pending state |
| pkt_pc | input | PC_W | Address of the packet |
| pkt_len | input | LEN_W | Packet length in bytes |
| pkt_end | input | 1 | End of packet; starts the commit sequence |
| reg_wr_en | input | 1 | Register write request |
| reg_wr_idx | input | log2(NUM_REGS) | Register index |
| reg_wr_val | input | REG_W | Register value |
| pred_wr_en | input | 1 | Predicate write request |
| pred_wr_idx | input | log2(NUM_PREDS) | Predicate index |
| pred_wr_val | input | REG_W | Predicate value (low byte kept) |
| br_req | input | 1 | Branch request |
| br_target | input | PC_W | Branch target |
| st_wr_en | input | 1 | Store record request |
| st_wr_slot | input | 1 | Store slot |
| st_wr_addr | input | ADDR_W | Store address |
| st_wr_width | input | 4 | Store width in bytes |
| st_wr_data | input | 64 | Store data |
| cancel_in | input | 2 | Slot cancel bits, ORed into the packet's mask |
| ld_req | input | 1 | Load waiting to issue (held until granted) |
| ld_slot | input | 1 | Slot of the load |
| ld_grant | output | 1 | Load may proceed |
| reg_cm_en | output | 1 | Committed register write valid |
| reg_cm_idx | output | log2(NUM_REGS) | Committed register index |
| reg_cm_val | output | REG_W | Committed register value |
| pred_cm_en | output | NUM_PREDS | Committed predicate enables |
| pred_cm_val | output | 8*NUM_PREDS | Committed predicate bytes |
| pc_valid | output | 1 | Final commit cycle; next_pc valid |
| next_pc | output | PC_W | Next program counter |
| br_misalign | output | 1 | Misaligned branch seen in this packet |
| st_width_err | output | 1 | Illegal store width seen in this packet |
| mem_st_valid | output | 1 | Store request to memory |
| mem_st_slot | output | 1 | Slot of the issued store |
| mem_st_addr | output | ADDR_W | Store address |
| mem_st_width | output | 4 | Store width in bytes |
| mem_st_data | output | 64 | Store data, masked to width |

## Verification
The bench builds the block with its defaults: 32 registers of 32 bits, four predicates, 32-bit addresses and a 5-bit length. This small configuration lets every predicate receive one to three ANDed writes in each pattern. It also allows a sweep of all 16 width codes of slot 0 against all four cancel masks, and of every alignment pair of two branch targets. Register sweeps repeat indices so that last-write-wins and ascending drain order both show. The four load cases (live slot-1 store, cancelled slot-1 store, slot-1 load, no slot-1 store) exercise the early-issue path and its grant latency.

// File: rtl/pcb_pkg.sv
// Shared constants, phase encoding and store helpers for the packet
// commit buffer. Assumes two store slots and byte-count width codes.
package pcb_pkg;

    localparam int PRED_W    = 8;
    localparam int ST_DATA_W = 64;
    localparam int WID_W     = 4;
    localparam int NUM_SLOTS = 2;

    typedef enum logic [2:0] {
        PH_COLLECT = 3'd0,
        PH_REGS    = 3'd1,
        PH_ST0     = 3'd2,
        PH_ST1     = 3'd3,
        PH_FIN     = 3'd4
    } phase_t;

    // True for the four legal byte counts.
    function automatic logic width_ok(input logic [WID_W-1:0] w);
        return (w == 4'd1) || (w == 4'd2) || (w == 4'd4) || (w == 4'd8);
    endfunction

    // Zero the data bits above the store width.
    function automatic logic [ST_DATA_W-1:0] mask_data(input logic [WID_W-1:0] w,
                                                       input logic [ST_DATA_W-1:0] d);
        case (w)
            4'd1:    return {56'b0, d[7:0]};
            4'd2:    return {48'b0, d[15:0]};
            4'd4:    return {32'b0, d[31:0]};
            default: return d;
        endcase
    endfunction

endpackage

// File: rtl/pcb_reg_buf.sv
// Pending register writes of one packet. Holds one value and one written
// flag per register; repeated writes overwrite. During drain, emits the
// lowest pending index each cycle and clears its flag.
// Assumes NUM_REGS is a power of two. Value storage is not reset; only
// the flags are.
module pcb_reg_buf #(
    parameter int NUM_REGS = 32,
    parameter int REG_W    = 32,
    localparam int IDX_W   = $clog2(NUM_REGS)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             collect,
    input  logic             pkt_start,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] wr_idx,
    input  logic [REG_W-1:0] wr_val,
    input  logic             drain_en,
    output logic             pending,
    output logic             cm_en,
    output logic [IDX_W-1:0] cm_idx,
    output logic [REG_W-1:0] cm_val
);

    logic [NUM_REGS-1:0] written_q;
    logic [REG_W-1:0]    val_q [NUM_REGS];
    logic [IDX_W-1:0]    low_idx;

    assign pending = |written_q;

    // Find the lowest-numbered register still waiting to commit.
    always_comb begin
        low_idx = '0;
        for (int i = NUM_REGS - 1; i >= 0; i--) begin
            if (written_q[i]) low_idx = IDX_W'(i);
        end
    end

    // Capture values; a write in the start cycle belongs to the new packet.
    always_ff @(posedge clk) begin
        if (collect && wr_en) val_q[wr_idx] <= wr_val;
    end

    // Track written flags and drain one register per cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            written_q <= '0;
            cm_en     <= 1'b0;
            cm_idx    <= '0;
            cm_val    <= '0;
        end else begin
            cm_en <= 1'b0;
            if (collect && pkt_start) written_q <= '0;
            if (collect && wr_en) written_q[wr_idx] <= 1'b1;
            if (drain_en && pending) begin
                cm_en              <= 1'b1;
                cm_idx             <= low_idx;
                cm_val             <= val_q[low_idx];
                written_q[low_idx] <= 1'b0;
            end
        end
    end

endmodule

// File: rtl/pcb_pred_buf.sv
// Pending predicate writes. The first write in a packet loads the low
// byte; later writes AND into it. On the final commit cycle the written
// mask and all pending bytes are presented for one cycle.
module pcb_pred_buf
    import pcb_pkg::*;
#(
    parameter int NUM_PREDS = 4,
    parameter int REG_W     = 32,
    localparam int PIDX_W   = (NUM_PREDS > 1) ? $clog2(NUM_PREDS) : 1
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        collect,
    input  logic                        pkt_start,
    input  logic                        wr_en,
    input  logic [PIDX_W-1:0]           wr_idx,
    input  logic [REG_W-1:0]            wr_val,
    input  logic                        fin,
    output logic [NUM_PREDS-1:0]        cm_en,
    output logic [NUM_PREDS*PRED_W-1:0] cm_val
);

    logic [NUM_PREDS-1:0]        written;
    logic [NUM_PREDS*PRED_W-1:0] pend_flat;
    logic [PRED_W-1:0]           new_byte;
    logic [REG_W-PRED_W-1:0]     unused_hi;

    assign new_byte  = wr_val[PRED_W-1:0];
    assign unused_hi = wr_val[REG_W-1:PRED_W];

    for (genvar p = 0; p < NUM_PREDS; p++) begin : g_pred
        logic              wr_q;
        logic [PRED_W-1:0] byte_q;
        logic              hit;
        logic              first;

        assign hit   = collect && wr_en && (wr_idx == PIDX_W'(p));
        assign first = !wr_q || pkt_start;

        // Load on first write of the packet, AND on every later one.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                wr_q   <= 1'b0;
                byte_q <= '0;
            end else begin
                if (collect && pkt_start) wr_q <= 1'b0;
                if (hit) begin
                    wr_q   <= 1'b1;
                    byte_q <= first ? new_byte : (byte_q & new_byte);
                end
            end
        end

        assign written[p]                    = wr_q;
        assign pend_flat[p*PRED_W +: PRED_W] = byte_q;
    end

    // Present the predicate results on the final commit cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cm_en  <= '0;
            cm_val <= '0;
        end else begin
            cm_en <= fin ? written : '0;
            if (fin) cm_val <= pend_flat;
        end
    end

endmodule

// File: rtl/pcb_branch.sv
// Next-PC selection for one packet. Latches the packet address and length
// at start and keeps the first aligned branch target. A misaligned target
// seen before any taken branch raises a flag and is dropped.
module pcb_branch #(
    parameter int PC_W  = 32,
    parameter int LEN_W = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             collect,
    input  logic             pkt_start,
    input  logic [PC_W-1:0]  pkt_pc,
    input  logic [LEN_W-1:0] pkt_len,
    input  logic             br_req,
    input  logic [PC_W-1:0]  br_target,
    input  logic             fin,
    output logic             pc_valid,
    output logic [PC_W-1:0]  next_pc,
    output logic             br_misalign
);

    logic            taken_q;
    logic [PC_W-1:0] target_q;
    logic [PC_W-1:0] base_q;
    logic [PC_W-1:0] len_q;
    logic            req_live;

    assign req_live = collect && br_req && (!taken_q || pkt_start);

    // Record packet origin and the first accepted branch.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            taken_q     <= 1'b0;
            target_q    <= '0;
            base_q      <= '0;
            len_q       <= '0;
            br_misalign <= 1'b0;
        end else begin
            if (collect && pkt_start) begin
                taken_q     <= 1'b0;
                br_misalign <= 1'b0;
                base_q      <= pkt_pc;
                len_q       <= PC_W'(pkt_len);
            end
            if (req_live) begin
                if (br_target[1:0] != 2'b00) begin
                    br_misalign <= 1'b1;
                end else begin
                    taken_q  <= 1'b1;
                    target_q <= br_target;
                end
            end
        end
    end

    // Publish the next PC on the final commit cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pc_valid <= 1'b0;
            next_pc  <= '0;
        end else begin
            pc_valid <= fin;
            if (fin) next_pc <= taken_q ? target_q : (base_q + len_q);
        end
    end

endmodule

// File: rtl/pcb_store_slots.sv
// Two store slots with cancel tracking and the single memory store port.
// A slot-0 load facing a live slot-1 store sends that store first; the
// load is granted on a later cycle. At commit the controller names a slot
// per cycle and the slot goes out unless empty, cancelled or already sent.
// Assumes ld_req is held until ld_grant.
module pcb_store_slots
    import pcb_pkg::*;
#(
    parameter int ADDR_W = 32
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 collect,
    input  logic                 pkt_start,
    input  logic                 st_wr_en,
    input  logic                 st_wr_slot,
    input  logic [ADDR_W-1:0]    st_wr_addr,
    input  logic [WID_W-1:0]     st_wr_width,
    input  logic [ST_DATA_W-1:0] st_wr_data,
    input  logic [NUM_SLOTS-1:0] cancel_in,
    input  logic                 ld_req,
    input  logic                 ld_slot,
    input  logic                 issue_en,
    input  logic                 issue_slot,
    output logic                 ld_grant,
    output logic                 width_err,
    output logic                 mem_st_valid,
    output logic                 mem_st_slot,
    output logic [ADDR_W-1:0]    mem_st_addr,
    output logic [WID_W-1:0]     mem_st_width,
    output logic [ST_DATA_W-1:0] mem_st_data
);

    logic [NUM_SLOTS-1:0] slot_valid;
    logic [NUM_SLOTS-1:0] slot_cancel;
    logic [NUM_SLOTS-1:0] slot_sent;
    logic [ADDR_W-1:0]    slot_addr  [NUM_SLOTS];
    logic [WID_W-1:0]     slot_width [NUM_SLOTS];
    logic [ST_DATA_W-1:0] slot_data  [NUM_SLOTS];
    logic [NUM_SLOTS-1:0] cancel_now;
    logic                 early_go;
    logic                 commit_go;
    logic                 go;
    logic                 go_slot;
    logic                 bad_width;

    assign cancel_now = slot_cancel | (collect ? cancel_in : '0);
    assign early_go   = collect && ld_req && !ld_slot && slot_valid[1]
                        && !cancel_now[1] && !slot_sent[1];
    assign commit_go  = issue_en && slot_valid[issue_slot]
                        && !slot_cancel[issue_slot] && !slot_sent[issue_slot];
    assign go         = early_go || commit_go;
    assign go_slot    = early_go ? 1'b1 : issue_slot;
    assign bad_width  = collect && st_wr_en && !width_ok(st_wr_width);

    for (genvar s = 0; s < NUM_SLOTS; s++) begin : g_slot
        logic                 v_q;
        logic                 c_q;
        logic                 sent_q;
        logic [ADDR_W-1:0]    a_q;
        logic [WID_W-1:0]     w_q;
        logic [ST_DATA_W-1:0] d_q;
        logic                 accept;

        assign accept = collect && st_wr_en && (st_wr_slot == 1'(s))
                        && width_ok(st_wr_width);

        // Slot contents, cancel and sent state for one packet.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                v_q    <= 1'b0;
                c_q    <= 1'b0;
                sent_q <= 1'b0;
                a_q    <= '0;
                w_q    <= '0;
                d_q    <= '0;
            end else begin
                if (collect && pkt_start) begin
                    v_q    <= 1'b0;
                    c_q    <= 1'b0;
                    sent_q <= 1'b0;
                end
                if (collect && cancel_in[s]) c_q <= 1'b1;
                if (go && (go_slot == 1'(s))) sent_q <= 1'b1;
                if (accept) begin
                    v_q    <= 1'b1;
                    sent_q <= 1'b0;
                    a_q    <= st_wr_addr;
                    w_q    <= st_wr_width;
                    d_q    <= st_wr_data;
                end
            end
        end

        assign slot_valid[s]  = v_q;
        assign slot_cancel[s] = c_q;
        assign slot_sent[s]   = sent_q;
        assign slot_addr[s]   = a_q;
        assign slot_width[s]  = w_q;
        assign slot_data[s]   = d_q;
    end

    // Packet-scoped illegal width flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            width_err <= 1'b0;
        end else begin
            if (collect && pkt_start) width_err <= 1'b0;
            if (bad_width) width_err <= 1'b1;
        end
    end

    // Memory store port and load grant.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mem_st_valid <= 1'b0;
            mem_st_slot  <= 1'b0;
            mem_st_addr  <= '0;
            mem_st_width <= '0;
            mem_st_data  <= '0;
            ld_grant     <= 1'b0;
        end else begin
            mem_st_valid <= go;
            ld_grant     <= collect && ld_req && !early_go;
            if (go) begin
                mem_st_slot  <= go_slot;
                mem_st_addr  <= slot_addr[go_slot];
                mem_st_width <= slot_width[go_slot];
                mem_st_data  <= mask_data(slot_width[go_slot], slot_data[go_slot]);
            end
        end
    end

endmodule

// File: rtl/pkt_commit_buf.sv
// Packet commit buffer top. Collects side effects while in the collect
// phase, then on pkt_end steps through: drain registers, slot-0 store,
// slot-1 store, final cycle (predicates and next PC). Inputs other than
// the load handshake are ignored outside the collect phase; callers are
// expected not to start a new packet before pc_valid.
module pkt_commit_buf
    import pcb_pkg::*;
#(
    parameter int NUM_REGS  = 32,
    parameter int REG_W     = 32,
    parameter int NUM_PREDS = 4,
    parameter int ADDR_W    = 32,
    parameter int PC_W      = 32,
    parameter int LEN_W     = 5,
    localparam int IDX_W    = $clog2(NUM_REGS),
    localparam int PIDX_W   = (NUM_PREDS > 1) ? $clog2(NUM_PREDS) : 1
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        pkt_start,
    input  logic [PC_W-1:0]             pkt_pc,
    input  logic [LEN_W-1:0]            pkt_len,
    input  logic                        pkt_end,
    input  logic                        reg_wr_en,
    input  logic [IDX_W-1:0]            reg_wr_idx,
    input  logic [REG_W-1:0]            reg_wr_val,
    input  logic                        pred_wr_en,
    input  logic [PIDX_W-1:0]           pred_wr_idx,
    input  logic [REG_W-1:0]            pred_wr_val,
    input  logic                        br_req,
    input  logic [PC_W-1:0]             br_target,
    input  logic                        st_wr_en,
    input  logic                        st_wr_slot,
    input  logic [ADDR_W-1:0]           st_wr_addr,
    input  logic [WID_W-1:0]            st_wr_width,
    input  logic [ST_DATA_W-1:0]        st_wr_data,
    input  logic [NUM_SLOTS-1:0]        cancel_in,
    input  logic                        ld_req,
    input  logic                        ld_slot,
    output logic                        ld_grant,
    output logic                        reg_cm_en,
    output logic [IDX_W-1:0]            reg_cm_idx,
    output logic [REG_W-1:0]            reg_cm_val,
    output logic [NUM_PREDS-1:0]        pred_cm_en,
    output logic [NUM_PREDS*PRED_W-1:0] pred_cm_val,
    output logic                        pc_valid,
    output logic [PC_W-1:0]             next_pc,
    output logic                        br_misalign,
    output logic                        st_width_err,
    output logic                        mem_st_valid,
    output logic                        mem_st_slot,
    output logic [ADDR_W-1:0]           mem_st_addr,
    output logic [WID_W-1:0]            mem_st_width,
    output logic [ST_DATA_W-1:0]        mem_st_data
);

    phase_t phase_q;
    logic   collect;
    logic   drain_en;
    logic   issue_en;
    logic   issue_slot;
    logic   fin;
    logic   reg_pending;

    assign collect    = (phase_q == PH_COLLECT);
    assign drain_en   = (phase_q == PH_REGS);
    assign issue_en   = (phase_q == PH_ST0) || (phase_q == PH_ST1);
    assign issue_slot = (phase_q == PH_ST1);
    assign fin        = (phase_q == PH_FIN);

    // Commit sequencer: collect -> registers -> slot 0 -> slot 1 -> final.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase_q <= PH_COLLECT;
        end else begin
            case (phase_q)
                PH_COLLECT: if (pkt_end) phase_q <= PH_REGS;
                PH_REGS:    if (!reg_pending) phase_q <= PH_ST0;
                PH_ST0:     phase_q <= PH_ST1;
                PH_ST1:     phase_q <= PH_FIN;
                default:    phase_q <= PH_COLLECT;
            endcase
        end
    end

    pcb_reg_buf #(
        .NUM_REGS (NUM_REGS),
        .REG_W    (REG_W)
    ) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .collect   (collect),
        .pkt_start (pkt_start),
        .wr_en     (reg_wr_en),
        .wr_idx    (reg_wr_idx),
        .wr_val    (reg_wr_val),
        .drain_en  (drain_en),
        .pending   (reg_pending),
        .cm_en     (reg_cm_en),
        .cm_idx    (reg_cm_idx),
        .cm_val    (reg_cm_val)
    );

    pcb_pred_buf #(
        .NUM_PREDS (NUM_PREDS),
        .REG_W     (REG_W)
    ) u_preds (
        .clk       (clk),
        .rst_n     (rst_n),
        .collect   (collect),
        .pkt_start (pkt_start),
        .wr_en     (pred_wr_en),
        .wr_idx    (pred_wr_idx),
        .wr_val    (pred_wr_val),
        .fin       (fin),
        .cm_en     (pred_cm_en),
        .cm_val    (pred_cm_val)
    );

    pcb_branch #(
        .PC_W  (PC_W),
        .LEN_W (LEN_W)
    ) u_branch (
        .clk         (clk),
        .rst_n       (rst_n),
        .collect     (collect),
        .pkt_start   (pkt_start),
        .pkt_pc      (pkt_pc),
        .pkt_len     (pkt_len),
        .br_req      (br_req),
        .br_target   (br_target),
        .fin         (fin),
        .pc_valid    (pc_valid),
        .next_pc     (next_pc),
        .br_misalign (br_misalign)
    );

    pcb_store_slots #(
        .ADDR_W (ADDR_W)
    ) u_stores (
        .clk          (clk),
        .rst_n        (rst_n),
        .collect      (collect),
        .pkt_start    (pkt_start),
        .st_wr_en     (st_wr_en),
        .st_wr_slot   (st_wr_slot),
        .st_wr_addr   (st_wr_addr),
        .st_wr_width  (st_wr_width),
        .st_wr_data   (st_wr_data),
        .cancel_in    (cancel_in),
        .ld_req       (ld_req),
        .ld_slot      (ld_slot),
        .issue_en     (issue_en),
        .issue_slot   (issue_slot),
        .ld_grant     (ld_grant),
        .width_err    (st_width_err),
        .mem_st_valid (mem_st_valid),
        .mem_st_slot  (mem_st_slot),
        .mem_st_addr  (mem_st_addr),
        .mem_st_width (mem_st_width),
        .mem_st_data  (mem_st_data)
    );

endmodule

// File: rtl/pcb_checker.sv
// Property checker for the packet commit buffer, bound to the top.
// Observes only the top-level outputs.
module pcb_checker #(
    parameter int NUM_PREDS = 4
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 ld_grant,
    input logic                 reg_cm_en,
    input logic [NUM_PREDS-1:0] pred_cm_en,
    input logic                 pc_valid,
    input logic                 mem_st_valid,
    input logic [3:0]           mem_st_width,
    input logic [63:0]          mem_st_data
);

    // R12
    reset_quiet_chk: assert property (@(posedge clk)
        !rst_n |=> (!mem_st_valid && !pc_valid && !reg_cm_en && !ld_grant
                    && (pred_cm_en == '0)));

    // R7
    legal_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_st_valid |-> ($countones(mem_st_width) == 1));

    // R6
    data_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_st_valid && (mem_st_width != 4'd8)) |-> (mem_st_data[63:32] == 32'h0));

    // R10
    one_event_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({mem_st_valid, reg_cm_en, pc_valid}));

    // R10
    fin_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pc_valid |=> !pc_valid);

    // R9
    grant_after_store_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_st_valid |-> !ld_grant);

    // R1
    pred_only_final_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pred_cm_en != '0) |-> pc_valid);

endmodule

bind pkt_commit_buf pcb_checker #(
    .NUM_PREDS (NUM_PREDS)
) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .ld_grant     (ld_grant),
    .reg_cm_en    (reg_cm_en),
    .pred_cm_en   (pred_cm_en),
    .pc_valid     (pc_valid),
    .mem_st_valid (mem_st_valid),
    .mem_st_width (mem_st_width),
    .mem_st_data  (mem_st_data)
);

// File: tb/pkt_commit_buf_test.sv
// Self-checking bench: sweeps predicate AND patterns, branch alignment
// pairs, store width codes against cancel masks, register orderings and
// the load ordering cases.
module pkt_commit_buf_test;

    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        pkt_start = 1'b0;
    logic [31:0] pkt_pc = '0;
    logic [4:0]  pkt_len = '0;
    logic        pkt_end = 1'b0;
    logic        reg_wr_en = 1'b0;
    logic [4:0]  reg_wr_idx = '0;
    logic [31:0] reg_wr_val = '0;
    logic        pred_wr_en = 1'b0;
    logic [1:0]  pred_wr_idx = '0;
    logic [31:0] pred_wr_val = '0;
    logic        br_req = 1'b0;
    logic [31:0] br_target = '0;
    logic        st_wr_en = 1'b0;
    logic        st_wr_slot = 1'b0;
    logic [31:0] st_wr_addr = '0;
    logic [3:0]  st_wr_width = '0;
    logic [63:0] st_wr_data = '0;
    logic [1:0]  cancel_in = '0;
    logic        ld_req = 1'b0;
    logic        ld_slot = 1'b0;
    logic        ld_grant;
    logic        reg_cm_en;
    logic [4:0]  reg_cm_idx;
    logic [31:0] reg_cm_val;
    logic [3:0]  pred_cm_en;
    logic [31:0] pred_cm_val;
    logic        pc_valid;
    logic [31:0] next_pc;
    logic        br_misalign;
    logic        st_width_err;
    logic        mem_st_valid;
    logic        mem_st_slot;
    logic [31:0] mem_st_addr;
    logic [3:0]  mem_st_width;
    logic [63:0] mem_st_data;

    pkt_commit_buf uut (.*);

    always #(CLK_PERIOD / 2) clk = ~clk;

    int n_chk = 0;
    int n_fail = 0;
    int cyc = 0;
    bit done = 0;

    always @(posedge clk) cyc <= cyc + 1;

    // Event logs filled by the monitor.
    int          st_n, rg_n, pc_cyc;
    logic        st_slot [8];
    logic [31:0] st_addr [8];
    logic [3:0]  st_width [8];
    logic [63:0] st_data [8];
    int          st_cyc [8];
    logic [4:0]  rg_idx [40];
    logic [31:0] rg_val [40];
    int          rg_cyc [40];
    bit          pc_seen;
    logic [31:0] pc_val;
    logic [3:0]  pr_en;
    logic [31:0] pr_val;

    always @(negedge clk) begin
        if (rst_n && mem_st_valid && st_n < 8) begin
            st_slot[st_n] = mem_st_slot;  st_addr[st_n] = mem_st_addr;
            st_width[st_n] = mem_st_width; st_data[st_n] = mem_st_data;
            st_cyc[st_n] = cyc; st_n++;
        end
        if (rst_n && reg_cm_en && rg_n < 40) begin
            rg_idx[rg_n] = reg_cm_idx; rg_val[rg_n] = reg_cm_val;
            rg_cyc[rg_n] = cyc; rg_n++;
        end
        if (rst_n && pc_valid) begin
            pc_seen = 1; pc_val = next_pc; pc_cyc = cyc;
            pr_en = pred_cm_en; pr_val = pred_cm_val;
        end
    end

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic tick();
        @(negedge clk);
    endtask

    task automatic pkt_begin(input logic [31:0] pc, input logic [4:0] len);
        st_n = 0; rg_n = 0; pc_seen = 0;
        pkt_start = 1; pkt_pc = pc; pkt_len = len;
        tick();
        pkt_start = 0;
    endtask

    task automatic wr_reg(input logic [4:0] idx, input logic [31:0] val);
        reg_wr_en = 1; reg_wr_idx = idx; reg_wr_val = val;
        tick();
        reg_wr_en = 0;
    endtask

    task automatic wr_pred(input logic [1:0] idx, input logic [31:0] val);
        pred_wr_en = 1; pred_wr_idx = idx; pred_wr_val = val;
        tick();
        pred_wr_en = 0;
    endtask

    task automatic branch(input logic [31:0] t);
        br_req = 1; br_target = t;
        tick();
        br_req = 0;
    endtask

    task automatic store(input logic s, input logic [31:0] a, input logic [3:0] w,
                         input logic [63:0] d);
        st_wr_en = 1; st_wr_slot = s; st_wr_addr = a; st_wr_width = w; st_wr_data = d;
        tick();
        st_wr_en = 0;
    endtask

    task automatic cancel(input logic [1:0] m);
        cancel_in = m;
        tick();
        cancel_in = 0;
    endtask

    task automatic pkt_finish();
        int n;
        pkt_end = 1;
        tick();
        pkt_end = 0;
        n = 0;
        while (!pc_seen && n < 100) begin tick(); n++; end
        chk("R10 commit completes", 64'(pc_seen), 64'd1);
    endtask

    function automatic logic [63:0] mask_w(input logic [3:0] w, input logic [63:0] d);
        if (w == 1) return d & 64'hFF;
        if (w == 2) return d & 64'hFFFF;
        if (w == 4) return d & 64'hFFFF_FFFF;
        return d;
    endfunction

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog (R10): actual hung expected finished");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (4) tick();
        rst_n = 1;
        tick();
        // R12 reset state
        chk("R12 mem_st_valid", 64'(mem_st_valid), 0);
        chk("R12 pc_valid", 64'(pc_valid), 0);
        chk("R12 reg_cm_en", 64'(reg_cm_en), 0);
        chk("R12 ld_grant", 64'(ld_grant), 0);
        chk("R12 pred_cm_en", 64'(pred_cm_en), 0);

        // R1 R2 predicate AND patterns
        for (int pat = 0; pat < 8; pat++) begin
            logic [7:0] exp_b [4];
            pkt_begin(32'h100, 5'd4);
            for (int p = 0; p < 4; p++) begin
                int nw;
                nw = ((pat + p) % 3) + 1;
                for (int k = 0; k < nw; k++) begin
                    logic [7:0] b;
                    b = 8'((pat * 37 + p * 101 + k * 59 + 93) ^ (k * 51));
                    exp_b[p] = (k == 0) ? b : (exp_b[p] & b);
                    wr_pred(2'(p), {24'hC3A5F0 ^ 24'(k), b});
                end
            end
            pkt_finish();
            chk("R1 pred enables", 64'(pr_en), 64'hF);
            for (int p = 0; p < 4; p++)
                chk("R2 pred AND byte", 64'(pr_val[p*8 +: 8]), 64'(exp_b[p]));
        end

        // R11 predicate flags cleared at packet start
        pkt_begin(32'h100, 5'd4);
        wr_pred(2'd2, 32'hFFFF_FF3C);
        pkt_finish();
        chk("R11 pred enables after start", 64'(pr_en), 64'b0100);
        chk("R11 pred byte not ANDed with old", 64'(pr_val[23:16]), 64'h3C);

        // R3 R4 R5 branch alignment pairs
        for (int a = 0; a < 4; a++) begin
            for (int b = 0; b < 4; b++) begin
                logic [31:0] pc, exp_pc;
                logic [4:0]  len;
                pc  = 32'h400 + 32'((a * 4 + b) * 64);
                len = 5'(4 * (b + 1));
                pkt_begin(pc, len);
                branch(32'h2000 | 32'(a));
                branch(32'h3000 | 32'(b));
                pkt_finish();
                exp_pc = (a == 0) ? 32'h2000 : ((b == 0) ? 32'h3000 : pc + 32'(len));
                chk("R3 R4 next_pc", 64'(pc_val), 64'(exp_pc));
                chk("R4 misalign flag", 64'(br_misalign), 64'(a != 0));
            end
        end
        pkt_begin(32'h8000, 5'd16);
        pkt_finish();
        chk("R5 fall-through pc", 64'(pc_val), 64'h8010);
        chk("R11 misalign cleared", 64'(br_misalign), 0);

        // R6 R7 R8 store widths against cancel masks
        for (int w = 0; w < 16; w++) begin
            for (int c = 0; c < 4; c++) begin
                logic        ok;
                int          en;
                logic        e_slot [2];
                logic [31:0] e_addr [2];
                logic [3:0]  e_w [2];
                logic [63:0] e_d [2];
                logic [63:0] d0;
                d0 = 64'h1122_3344_5566_7788 ^ 64'(w * 16'h0101);
                ok = (w == 1) || (w == 2) || (w == 4) || (w == 8);
                pkt_begin(32'h0, 5'd4);
                store(1'b0, 32'h100 + 32'(w), 4'(w), d0);
                store(1'b1, 32'h200, 4'd8, 64'hCAFE_F00D_DEAD_BEEF);
                cancel(2'(c));
                pkt_finish();
                en = 0;
                if (ok && !c[0]) begin
                    e_slot[en] = 0; e_addr[en] = 32'h100 + 32'(w); e_w[en] = 4'(w);
                    e_d[en] = mask_w(4'(w), d0); en++;
                end
                if (!c[1]) begin
                    e_slot[en] = 1; e_addr[en] = 32'h200; e_w[en] = 4'd8;
                    e_d[en] = 64'hCAFE_F00D_DEAD_BEEF; en++;
                end
                chk("R8 R7 store count", 64'(st_n), 64'(en));
                chk("R7 width error flag", 64'(st_width_err), 64'(!ok));
                for (int i = 0; i < en; i++) begin
                    if (i < st_n) begin
                        chk("R10 store slot order", 64'(st_slot[i]), 64'(e_slot[i]));
                        chk("R6 store addr", 64'(st_addr[i]), 64'(e_addr[i]));
                        chk("R6 store width", 64'(st_width[i]), 64'(e_w[i]));
                        chk("R6 store data mask", st_data[i], e_d[i]);
                    end
                end
            end
        end

        // R13 R10 register drain order and last-write-wins
        for (int j = 0; j < 4; j++) begin
            bit          e_wr [32];
            logic [31:0] e_val [32];
            int          ei;
            for (int r = 0; r < 32; r++) e_wr[r] = 0;
            pkt_begin(32'h40, 5'd8);
            for (int k = 0; k < 6; k++) begin
                int ix;
                ix = (j * 5 + (k % 4) * 11) % 32;
                e_wr[ix] = 1; e_val[ix] = 32'h1000_0000 * 32'(j) + 32'(k * 273 + 1);
                wr_reg(5'(ix), e_val[ix]);
            end
            store(1'b0, 32'h500, 4'd4, 64'h0000_0000_0BAD_F00D);
            store(1'b1, 32'h504, 4'd2, 64'h0000_0000_0000_1234);
            pkt_finish();
            ei = 0;
            for (int r = 0; r < 32; r++) begin
                if (e_wr[r]) begin
                    if (ei < rg_n) begin
                        chk("R10 reg ascending index", 64'(rg_idx[ei]), 64'(r));
                        chk("R13 reg last value", 64'(rg_val[ei]), 64'(e_val[r]));
                    end
                    ei++;
                end
            end
            chk("R13 reg commit count", 64'(rg_n), 64'(ei));
            if (rg_n > 0 && st_n == 2) begin
                chk("R10 stores after regs", 64'(st_cyc[0] > rg_cyc[rg_n-1]), 1);
                chk("R10 slot1 after slot0", 64'(st_cyc[1] > st_cyc[0]), 1);
                chk("R10 pc after stores", 64'(pc_cyc > st_cyc[1]), 1);
            end else begin
                chk("R10 store count with regs", 64'(st_n), 2);
            end
        end

        // R9 load ordering cases
        for (int cs = 0; cs < 4; cs++) begin
            int  req_c, g_c, n, pre_n;
            bit  early;
            pkt_begin(32'h0, 5'd4);
            store(1'b0, 32'h600, 4'd4, 64'h0000_0000_AAAA_0000);
            if (cs != 3) store(1'b1, 32'h700, 4'd4, 64'h0000_0000_BBBB_1111);
            if (cs == 1) cancel(2'b10);
            ld_req = 1; ld_slot = (cs == 2);
            req_c = cyc;
            n = 0; g_c = -1;
            while (g_c < 0 && n < 20) begin
                tick(); n++;
                if (ld_grant) g_c = cyc;
            end
            ld_req = 0; ld_slot = 0;
            pre_n = st_n;
            early = (cs == 0);
            if (early) begin
                chk("R9 early store count", 64'(pre_n), 1);
                chk("R9 early store slot", 64'(st_slot[0]), 1);
                chk("R9 early store cycle", 64'(st_cyc[0]), 64'(req_c + 1));
                chk("R9 grant after store", 64'(g_c), 64'(req_c + 2));
            end else begin
                chk("R9 no early store", 64'(pre_n), 0);
                chk("R9 direct grant", 64'(g_c), 64'(req_c + 1));
            end
            pkt_finish();
            chk("R9 R10 total stores", 64'(st_n), 64'((cs == 2) ? 2 : ((cs == 0) ? 2 : 1)));
            if (st_n >= pre_n + 1)
                chk("R10 commit slot0 first", 64'(st_slot[pre_n]), 0);
        end

        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

endmodule